// File: doc/BRIEF.md
# Tiered Write-Protection Lock Controller

This block guards the configuration fields of a motor-control timer against stray software writes. Software writes a 2-bit protection tier once after reset. From the next cycle on, each configuration field whose tier is at or below the captured tier ignores software writes. The fields keep their values until a timer reset or a system reset returns everything to zero and accepts a new tier. The tiers are cumulative, so each higher tier freezes every field of the lower tiers and adds fields of its own.

Two clock-related bits act differently from the other fields. These are the timer clock enable and the clock-monitor enable. While they are protected, a write can still set them but can never clear them.

The register port is synchronous: address, write data and write enable in, and registered read data out, valid one cycle after the address is presented. Every protected field is also driven straight out as a port, for the timer datapath to use.

Register layout (32-bit words):
- Address 0 holds the tier in bits [1:0].
- Address 1 holds the following fields:
  - dead-time in bits [7:0]
  - main idle states in [11:8] and complementary idle states in [15:12], one bit per channel
  - main polarities in [19:16] and complementary polarities in [23:20], one bit per channel
- Address 2 holds the following bits:
  - break enable in bit 0, break polarity in bit 1 and automatic output enable in bit 2
  - idle off-state select in bit 3 and run off-state select in bit 4
  - clock enable in bit 8 and clock-monitor enable in bit 9
- Address 3 holds one nibble per channel: channel n uses bits [4n+2:4n] for its output mode and bit 4n+3 for its compare preload enable.

Top module: `tmr_wprot_ctrl`

## Requirements
- R1: In the cycle after either reset, every field output, the tier and the read data are zero.
- R2: The tier register (address 0, bits [1:0]) captures only the first write after a reset, a value of 00 included. Later writes are ignored, and address 0 always reads back the captured tier.
- R3: A timer reset and a system reset each re-arm the tier register for one new write.
- R4: At tier 00, every field at addresses 1 to 3 takes any write.
- R5: At tier 01, the following fields ignore writes: dead-time, both idle-state sets, break enable, break polarity and automatic output enable. The polarities, off-state selects, clock bits and channel fields stay writable.
- R6: At tier 10, the polarities, both off-state selects and the two clock bits are protected as well. Channel modes and preload enables stay writable.
- R7: At tier 11, the channel output modes and preload enables are protected as well.
- R8: At tier 10 or above, a write can set the clock enable (address 2 bit 8) and the clock-monitor enable (bit 9) but cannot clear them.
- R9: A write that covers both protected and unprotected fields updates only the unprotected fields and raises no error.
- R10: Read data is registered, so it shows the word at the address presented in the previous cycle. Addresses 4 to 7 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| tmr_rst | input | 1 | Synchronous timer reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| lock_lvl | output | 2 | Captured protection tier |
| dead_time | output | 8 | Dead-time value |
| idle_main | output | 4 | Idle state of the main outputs, one bit per channel |
| idle_comp | output | 4 | Idle state of the complementary outputs, one bit per channel |
| brk_en | output | 1 | Break enable |
| brk_pol | output | 1 | Break polarity |
| auto_oe | output | 1 | Automatic output enable |
| pol_main | output | 4 | Main output polarity, one bit per channel |
| pol_comp | output | 4 | Complementary output polarity, one bit per channel |
| off_idle | output | 1 | Off-state select in idle mode |
| off_run | output | 1 | Off-state select in run mode |
| clk_en | output | 1 | Timer clock enable |
| clkmon_en | output | 1 | Clock-monitor enable |
| ch_mode | output | 12 | Output mode per channel, 3 bits each, channel 0 in the low bits |
| ch_preload | output | 4 | Compare preload enable per channel |

## Verification
The hardest situation to reach is a field that has just been frozen while the words around it still change. Examples are a protected field sharing a register word with writable fields, and a set-only clock bit that already holds 1 when a clear is attempted. The stimulus writes known values first, then captures a tier, then writes mixed words. These words set some bits and clear others, and the test observes each field port separately. A second write to the tier register follows each capture. That write is repeated after a timer reset and after a system reset, to show the write-once behaviour and the re-arming.

// File: rtl/tmr_wprot_pkg.sv
package tmr_wprot_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_LOCK = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_BRK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CHAN = 3'd3;

  typedef enum logic [1:0] {
    TIER_OFF = 2'b00,
    TIER_1   = 2'b01,
    TIER_2   = 2'b10,
    TIER_3   = 2'b11
  } tier_e;
endpackage

// File: rtl/wprot_lock_reg.sv
module wprot_lock_reg (
  input  logic       clk,
  input  logic       clr,
  input  logic       we,
  input  logic [1:0] wd,
  output logic [1:0] lvl
);
  logic armed;

  always_ff @(posedge clk) begin
    if (clr) begin
      lvl   <= 2'b00;
      armed <= 1'b1;
    end else if (we && armed) begin
      lvl   <= wd;
      armed <= 1'b0;
    end
  end

  // R2: after the one permitted write the tier cannot move
  p_lock_once_r2: assert property (@(posedge clk) disable iff (clr)
    !armed |=> $stable(lvl));
  // R2: the first write is captured whatever its value
  p_lock_capture_r2: assert property (@(posedge clk) disable iff (clr)
    (armed && we) |=> (lvl == $past(wd)));
endmodule

// File: rtl/wprot_tier_dec.sv
module wprot_tier_dec
  import tmr_wprot_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic [1:0] lvl,
  output logic       prot1,
  output logic       prot2,
  output logic       prot3
);
  always_comb begin
    prot1 = (lvl != TIER_OFF);
    prot2 = (lvl == TIER_2) || (lvl == TIER_3);
    prot3 = (lvl == TIER_3);
  end

  // R7: tiers nest, so a higher tier never leaves a lower tier open
  p_tier_nest_r7: assert property (@(posedge clk) disable iff (clr)
    prot3 |-> (prot2 && prot1));
endmodule

// File: rtl/wprot_field.sv
module wprot_field #(
  parameter int unsigned W        = 1,
  parameter bit          SET_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         we,
  input  logic         prot,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (SET_ONLY) begin : g_setonly
      always_ff @(posedge clk) begin
        if (clr)            q <= '0;
        else if (we && prot) q <= q | d;
        else if (we)         q <= d;
      end
      // R8: a protected set-only bit never falls
      p_no_clear_r8: assert property (@(posedge clk) disable iff (clr)
        prot |=> (($past(q) & ~q) == '0));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (clr)             q <= '0;
        else if (we && !prot) q <= d;
      end
      // R9: a protected field holds through any write
      p_frozen_r9: assert property (@(posedge clk) disable iff (clr)
        prot |=> $stable(q));
    end
  endgenerate

  // R1: either reset clears the field
  p_reset_clear_r1: assert property (@(posedge clk)
    clr |=> (q == '0));
endmodule

// File: rtl/tmr_wprot_ctrl.sv
module tmr_wprot_ctrl
  import tmr_wprot_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned MODE_W = 3,
  parameter int unsigned DT_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tmr_rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [1:0]             lock_lvl,
  output logic [DT_W-1:0]        dead_time,
  output logic [N_CH-1:0]        idle_main,
  output logic [N_CH-1:0]        idle_comp,
  output logic                   brk_en,
  output logic                   brk_pol,
  output logic                   auto_oe,
  output logic [N_CH-1:0]        pol_main,
  output logic [N_CH-1:0]        pol_comp,
  output logic                   off_idle,
  output logic                   off_run,
  output logic                   clk_en,
  output logic                   clkmon_en,
  output logic [N_CH*MODE_W-1:0] ch_mode,
  output logic [N_CH-1:0]        ch_preload
);
  localparam int unsigned IM_LSB = DT_W;
  localparam int unsigned IC_LSB = DT_W + N_CH;
  localparam int unsigned PM_LSB = DT_W + 2*N_CH;
  localparam int unsigned PC_LSB = DT_W + 3*N_CH;
  localparam int unsigned CH_STR = MODE_W + 1;
  localparam int unsigned CLK_B  = 8;

  logic clr;
  logic we_lock, we_out, we_brk, we_chan;
  logic prot1, prot2, prot3;
  logic [2:0] brk_q;
  logic [1:0] off_q, clk_q;
  logic [DATA_W-1:0] rd_nxt;
  logic unused_wd;

  assign clr     = rst | tmr_rst;
  assign we_lock = wr_en && (addr == A_LOCK);
  assign we_out  = wr_en && (addr == A_OUT);
  assign we_brk  = wr_en && (addr == A_BRK);
  assign we_chan = wr_en && (addr == A_CHAN);
  assign unused_wd = ^wdata[DATA_W-1:PC_LSB+N_CH];

  wprot_lock_reg u_lock (
    .clk(clk), .clr(clr), .we(we_lock), .wd(wdata[1:0]), .lvl(lock_lvl));

  wprot_tier_dec u_tier (
    .clk(clk), .clr(clr), .lvl(lock_lvl),
    .prot1(prot1), .prot2(prot2), .prot3(prot3));

  wprot_field #(.W(DT_W)) u_dt (
    .clk(clk), .clr(clr), .we(we_out), .prot(prot1),
    .d(wdata[DT_W-1:0]), .q(dead_time));
  wprot_field #(.W(N_CH)) u_im (
    .clk(clk), .clr(clr), .we(we_out), .prot(prot1),
    .d(wdata[IM_LSB +: N_CH]), .q(idle_main));
  wprot_field #(.W(N_CH)) u_ic (
    .clk(clk), .clr(clr), .we(we_out), .prot(prot1),
    .d(wdata[IC_LSB +: N_CH]), .q(idle_comp));
  wprot_field #(.W(N_CH)) u_pm (
    .clk(clk), .clr(clr), .we(we_out), .prot(prot2),
    .d(wdata[PM_LSB +: N_CH]), .q(pol_main));
  wprot_field #(.W(N_CH)) u_pc (
    .clk(clk), .clr(clr), .we(we_out), .prot(prot2),
    .d(wdata[PC_LSB +: N_CH]), .q(pol_comp));

  wprot_field #(.W(3)) u_brk (
    .clk(clk), .clr(clr), .we(we_brk), .prot(prot1),
    .d(wdata[2:0]), .q(brk_q));
  wprot_field #(.W(2)) u_off (
    .clk(clk), .clr(clr), .we(we_brk), .prot(prot2),
    .d(wdata[4:3]), .q(off_q));
  wprot_field #(.W(2), .SET_ONLY(1'b1)) u_clk (
    .clk(clk), .clr(clr), .we(we_brk), .prot(prot2),
    .d(wdata[CLK_B +: 2]), .q(clk_q));

  assign {auto_oe, brk_pol, brk_en} = brk_q;
  assign {off_run, off_idle}        = off_q;
  assign {clkmon_en, clk_en}        = clk_q;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [CH_STR-1:0] cq;
      wprot_field #(.W(CH_STR)) u_chf (
        .clk(clk), .clr(clr), .we(we_chan), .prot(prot3),
        .d(wdata[c*CH_STR +: CH_STR]), .q(cq));
      assign ch_mode[c*MODE_W +: MODE_W] = cq[MODE_W-1:0];
      assign ch_preload[c]               = cq[MODE_W];
    end
  endgenerate

  always_comb begin
    rd_nxt = '0;
    case (addr)
      A_LOCK: rd_nxt[1:0] = lock_lvl;
      A_OUT: begin
        rd_nxt[DT_W-1:0]       = dead_time;
        rd_nxt[IM_LSB +: N_CH] = idle_main;
        rd_nxt[IC_LSB +: N_CH] = idle_comp;
        rd_nxt[PM_LSB +: N_CH] = pol_main;
        rd_nxt[PC_LSB +: N_CH] = pol_comp;
      end
      A_BRK: begin
        rd_nxt[2:0]          = brk_q;
        rd_nxt[4:3]          = off_q;
        rd_nxt[CLK_B +: 2]   = clk_q;
      end
      A_CHAN: begin
        for (int c = 0; c < N_CH; c++) begin
          rd_nxt[c*CH_STR +: MODE_W] = ch_mode[c*MODE_W +: MODE_W];
          rd_nxt[c*CH_STR + MODE_W]  = ch_preload[c];
        end
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) rdata <= '0;
    else     rdata <= rd_nxt;
  end

  // R10: a read of the tier address returns the tier held before that edge
  p_rdata_lock_r10: assert property (@(posedge clk) disable iff (clr)
    (addr == A_LOCK) |=> (rdata == {{(DATA_W-2){1'b0}}, $past(lock_lvl)}));
endmodule

// File: tb/tmr_wprot_ctrl_tb.sv
module tmr_wprot_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst, tmr_rst, wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [1:0]  lock_lvl;
  logic [7:0]  dead_time;
  logic [3:0]  idle_main, idle_comp, pol_main, pol_comp, ch_preload;
  logic        brk_en, brk_pol, auto_oe, off_idle, off_run, clk_en, clkmon_en;
  logic [11:0] ch_mode;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_wprot_ctrl dut_i (
    .clk(clk), .rst(rst), .tmr_rst(tmr_rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lock_lvl(lock_lvl), .dead_time(dead_time),
    .idle_main(idle_main), .idle_comp(idle_comp), .brk_en(brk_en),
    .brk_pol(brk_pol), .auto_oe(auto_oe), .pol_main(pol_main),
    .pol_comp(pol_comp), .off_idle(off_idle), .off_run(off_run),
    .clk_en(clk_en), .clkmon_en(clkmon_en), .ch_mode(ch_mode),
    .ch_preload(ch_preload));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_rst(input bit sys);
    @(negedge clk);
    rst = sys; tmr_rst = !sys; wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0; tmr_rst = 1'b0;
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(posedge clk);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] w_out(input logic [7:0] dt, input logic [3:0] im,
    input logic [3:0] ic, input logic [3:0] pm, input logic [3:0] pc);
    return {8'h00, pc, pm, ic, im, dt};
  endfunction

  function automatic logic [11:0] modes_of(input logic [15:0] w);
    logic [11:0] m;
    for (int c = 0; c < 4; c++) m[c*3 +: 3] = w[c*4 +: 3];
    return m;
  endfunction

  function automatic logic [3:0] pre_of(input logic [15:0] w);
    logic [3:0] p;
    for (int c = 0; c < 4; c++) p[c] = w[c*4+3];
    return p;
  endfunction

  task automatic t_reset_state;
    logic [31:0] r;
    do_wr(3'd1, 32'h00FF_FFFF);
    do_wr(3'd2, 32'h0000_031F);
    do_wr(3'd3, 32'h0000_FFFF);
    do_rst(1'b0);
    check("R1 out fields", {8'h0, pol_comp, pol_main, idle_comp, idle_main, dead_time}, 32'h0);
    check("R1 brk/clk bits", {clkmon_en, clk_en, off_run, off_idle, auto_oe, brk_pol, brk_en}, 32'h0);
    check("R1 chan fields", {ch_preload, ch_mode}, 32'h0);
    check("R1 lock/rdata", {rdata[29:0], lock_lvl}, 32'h0);
  endtask

  task automatic t_level0;
    logic [31:0] r;
    do_rst(1'b1);
    do_wr(3'd1, w_out(8'h5A, 4'h3, 4'hC, 4'h9, 4'h6));
    do_rd(3'd1, r);
    check("R4 R10 out word", r, w_out(8'h5A, 4'h3, 4'hC, 4'h9, 4'h6));
    do_wr(3'd2, 32'h0000_0315);
    do_rd(3'd2, r);
    check("R4 R10 brk word", r, 32'h0000_0315);
    do_wr(3'd3, 32'h0000_A5C3);
    do_rd(3'd3, r);
    check("R4 R10 chan word", r, 32'h0000_A5C3);
    check("R4 ch_mode", {20'h0, ch_mode}, {20'h0, modes_of(16'hA5C3)});
    check("R4 ch_preload", {28'h0, ch_preload}, {28'h0, pre_of(16'hA5C3)});
    do_wr(3'd2, 32'h0);
    check("R4 clock bits clear when unlocked", {30'h0, clkmon_en, clk_en}, 32'h0);
  endtask

  task automatic t_lock_once;
    logic [31:0] r;
    do_rst(1'b1);
    do_wr(3'd0, 32'h0);
    do_wr(3'd0, 32'h3);
    do_rd(3'd0, r);
    check("R2 first write 00 sticks", r, 32'h0);
    do_wr(3'd1, w_out(8'h77, 4'h1, 4'h2, 4'h3, 4'h4));
    check("R2 no protection after 00", {24'h0, dead_time}, 32'h77);
    do_rst(1'b0);
    do_wr(3'd0, 32'h2);
    do_rd(3'd0, r);
    check("R3 timer reset re-arms", r, 32'h2);
    do_wr(3'd0, 32'h1);
    do_rd(3'd0, r);
    check("R2 second write ignored", r, 32'h2);
    do_rst(1'b1);
    do_wr(3'd0, 32'h1);
    check("R3 system reset re-arms", {30'h0, lock_lvl}, 32'h1);
  endtask

  task automatic t_level1;
    do_rst(1'b1);
    do_wr(3'd1, w_out(8'h55, 4'hA, 4'h5, 4'h3, 4'hC));
    do_wr(3'd0, 32'h1);
    do_wr(3'd1, w_out(8'hFF, 4'hF, 4'hF, 4'h9, 4'h6));
    check("R5 R9 dead-time/idle frozen", {16'h0, idle_comp, idle_main, dead_time}, 32'h5A55);
    check("R9 polarities updated in mixed write", {24'h0, pol_comp, pol_main}, 32'h69);
    do_wr(3'd2, 32'h0000_031F);
    check("R5 break bits frozen", {29'h0, auto_oe, brk_pol, brk_en}, 32'h0);
    check("R5 off/clk writable", {28'h0, clkmon_en, clk_en, off_run, off_idle}, 32'hF);
    do_wr(3'd2, 32'h0);
    check("R5 clock bits clearable at tier 1", {30'h0, clkmon_en, clk_en}, 32'h0);
  endtask

  task automatic t_level2;
    logic [31:0] r;
    do_rst(1'b1);
    do_wr(3'd2, 32'h0000_0100);
    do_wr(3'd1, w_out(8'h00, 4'h0, 4'h0, 4'h5, 4'hA));
    do_wr(3'd0, 32'h2);
    do_wr(3'd2, 32'h0000_0218);
    check("R8 set-only: monitor set, enable kept", {30'h0, clkmon_en, clk_en}, 32'h3);
    check("R6 off-state frozen", {30'h0, off_run, off_idle}, 32'h0);
    do_wr(3'd2, 32'h0);
    check("R8 no clear at tier 2", {30'h0, clkmon_en, clk_en}, 32'h3);
    do_wr(3'd1, w_out(8'h00, 4'h0, 4'h0, 4'hF, 4'h0));
    check("R6 polarities frozen", {24'h0, pol_comp, pol_main}, 32'hA5);
    do_wr(3'd3, 32'h0000_A5C3);
    do_rd(3'd3, r);
    check("R6 channels writable at tier 2", r, 32'h0000_A5C3);
  endtask

  task automatic t_level3;
    logic [31:0] r;
    do_rst(1'b1);
    do_wr(3'd3, 32'h0000_1234);
    do_wr(3'd0, 32'h3);
    do_wr(3'd3, 32'h0000_FFFF);
    do_rd(3'd3, r);
    check("R7 chan word frozen", r, 32'h0000_1234);
    check("R7 ch_mode frozen", {20'h0, ch_mode}, {20'h0, modes_of(16'h1234)});
    check("R7 ch_preload frozen", {28'h0, ch_preload}, 32'h0);
    do_wr(3'd2, 32'h0000_0300);
    do_wr(3'd2, 32'h0);
    check("R8 set-only at tier 3", {30'h0, clkmon_en, clk_en}, 32'h3);
  endtask

  task automatic t_unmapped;
    logic [31:0] r;
    do_rst(1'b1);
    do_wr(3'd5, 32'hFFFF_FFFF);
    check("R10 unmapped write no effect",
      {ch_preload, ch_mode, pol_comp, pol_main, dead_time[3:0], 1'b0, clk_en, brk_en, lock_lvl},
      32'h0);
    do_rd(3'd5, r);
    check("R10 unmapped reads zero", r, 32'h0);
  endtask

  initial begin
    rst = 1'b1; tmr_rst = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_level0();
    t_lock_once();
    t_level1();
    t_level2();
    t_level3();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule